// File: doc/BRIEF.md
# Oversampling Serial Receiver with Three-Sample Bit Voting

This block receives asynchronous serial characters. Each character has one low start bit, eight or nine data bits sent least significant bit first, and one high stop bit. The line is sampled on a 16x baud tick. Each bit is decided by a majority vote of three samples taken around the middle of the bit period. The character length is picked per character by a mode input, which is latched when the start edge is seen.

A finished character moves into a holding register that the host reads through a read strobe. Three status bits go with it. The receive-complete flag marks unread data. The framing-error flag records whether the held character had a bad stop bit; the character is delivered either way. The overrun flag records that a character was dropped while the register was still full. The overrun flag is deliberately delayed: it only shows up when the host reads the data that was pending, so the host checks it after each read. When the enable input is low, the receiver stays idle and ignores the line.

Top module: `uart_vote_rx`

## Requirements
- R1: Counting the tick on which the synchronised line is first seen low after being high as tick 1 of a bit period, each bit is sampled on ticks 8, 9 and 10 of its period. The bit value is the level seen on at least two of those three ticks. Bit periods are 16 ticks long.
- R2: A character is one start bit, then the data bits least significant first, then one stop bit. The data bits are 8 when `wide_mode` is 0 and 9 when it is 1. `rx_data` holds data bits 0 to 7.
- R3: If the vote on the start bit gives 1, the receiver returns to idle without delivering a character, and it accepts the next proper character.
- R4: `frame_err` is 1 exactly when the held character's stop-bit vote gave 0.
- R5: At the end of every character, including one with a bad stop bit, the data is loaded and `rx_done` becomes 1, as long as the register was empty.
- R6: `rx_bit9` holds the ninth data bit of a 9-bit character and reads 0 for an 8-bit character.
- R7: A one-cycle pulse on `rd_stb` while `rx_done` is 1 clears `rx_done` on the next clock.
- R8: A character that completes while `rx_done` is 1 and no read is taking place is dropped. `rx_data`, `rx_bit9` and `frame_err` keep the older character.
- R9: `overrun` changes only on a read. After reading data that had a dropped successor it reads 1. After a read with no drop pending it reads 0.
- R10: While `rx_en` is 0 the receiver is idle and line activity delivers nothing. After it is enabled again, the line must be seen high before a start edge is accepted.
- R11: After reset, `rx_done`, `frame_err`, `overrun`, `rx_bit9` and `rx_data` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_en | input | 1 | Receiver enable |
| tick16 | input | 1 | One-cycle pulse at 16 times the baud rate |
| rxd | input | 1 | Serial line input, asynchronous |
| wide_mode | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| rd_stb | input | 1 | Host read strobe for the data register |
| rx_data | output | 8 | Held data bits 0 to 7 |
| rx_bit9 | output | 1 | Held ninth data bit |
| rx_done | output | 1 | Unread character present |
| frame_err | output | 1 | Held character had a bad stop bit |
| overrun | output | 1 | Buffered overrun status, updated on read |

## Verification
The line input passes through a two-flop synchroniser, so a level driven just after a tick is seen by the next tick. The bench aligns every line change to that point, which lets it place glitches on exact sample positions. Status and data are registered one clock after the stop bit's tenth tick. The bench only checks them after two further idle bit periods, so they have long since settled. Read results are due one clock after the strobe edge, and the bench samples them on the falling edge that follows.

// File: rtl/uart_vote_pkg.sv
package uart_vote_pkg;

   typedef enum logic [1:0] {
      RX_IDLE,
      RX_START,
      RX_DATA,
      RX_STOP
   } rx_state_e;

endpackage

// File: rtl/uart_vote_sync.sv
module uart_vote_sync #(
   parameter int   STAGES    = 2,
   parameter logic RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);

   if (STAGES < 1 || STAGES > 4) begin : g_bad_stages
      $error("uart_vote_sync: STAGES must be 1..4");
   end

   if (STAGES == 1) begin : g_one
      logic ff_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) ff_q <= RESET_VAL;
         else        ff_q <= din;
      end
      assign dout = ff_q;
   end else begin : g_chain
      logic [STAGES-1:0] ff_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) ff_q <= {STAGES{RESET_VAL}};
         else        ff_q <= {ff_q[STAGES-2:0], din};
      end
      assign dout = ff_q[STAGES-1];
   end

endmodule

// File: rtl/uart_vote_maj.sv
module uart_vote_maj #(
   parameter int VOTES = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic smp_en,
   input  logic smp,
   output logic maj_now
);

   localparam int HW = VOTES - 1;

   if (VOTES < 3 || (VOTES % 2) == 0) begin : g_bad_votes
      $error("uart_vote_maj: VOTES must be odd and at least 3");
   end

   logic [HW-1:0] hist_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      hist_q <= '0;
      else if (smp_en) hist_q <= {hist_q[HW-2:0], smp};
   end

   // the current sample takes part so the decision is ready on the last tick
   assign maj_now = ($countones({hist_q, smp}) > (VOTES / 2));

endmodule

// File: rtl/uart_vote_frame.sv
module uart_vote_frame
   import uart_vote_pkg::*;
#(
   parameter int OSR        = 16,
   parameter int SAMP_FIRST = 8,
   parameter int VOTES      = 3,
   parameter int DATA_W     = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              tick,
   input  logic              rxd_s,
   input  logic              wide,
   input  logic              maj_now,
   output logic              smp_en,
   output logic              char_done,
   output logic [DATA_W:0]   char_data,
   output logic              stop_ok
);

   localparam int CW    = $clog2(OSR);
   localparam int IW    = $clog2(DATA_W + 2);
   localparam int FIRST = SAMP_FIRST - 1;
   localparam int LAST  = FIRST + VOTES - 1;
   localparam logic [CW-1:0] FIRST_C = CW'(FIRST);
   localparam logic [CW-1:0] LAST_C  = CW'(LAST);
   localparam logic [CW-1:0] WRAP_C  = CW'(OSR - 1);
   localparam logic [IW-1:0] TOP_N   = IW'(DATA_W - 1);
   localparam logic [IW-1:0] TOP_W   = IW'(DATA_W);

   if (SAMP_FIRST < 2 || LAST > OSR - 1) begin : g_bad_window
      $error("uart_vote_frame: sample window must sit inside the bit period");
   end

   rx_state_e       state_q;
   logic [CW-1:0]   cnt_q;
   logic [IW-1:0]   idx_q;
   logic [DATA_W:0] shreg_q;
   logic            prev_q;
   logic            wide_q;
   logic            at_last;

   assign at_last = tick && (state_q != RX_IDLE) && (cnt_q == LAST_C);
   assign smp_en  = en && tick && (state_q != RX_IDLE) &&
                    (cnt_q >= FIRST_C) && (cnt_q <= LAST_C);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= RX_IDLE;
         cnt_q     <= '0;
         idx_q     <= '0;
         shreg_q   <= '0;
         prev_q    <= 1'b0;
         wide_q    <= 1'b0;
         char_done <= 1'b0;
         stop_ok   <= 1'b0;
      end else begin
         char_done <= 1'b0;
         if (!en) begin
            state_q <= RX_IDLE;
            cnt_q   <= '0;
            prev_q  <= 1'b0;
         end else if (tick) begin
            prev_q <= rxd_s;
            if (state_q == RX_IDLE) begin
               if (prev_q && !rxd_s) begin
                  state_q <= RX_START;
                  cnt_q   <= CW'(1);
                  idx_q   <= '0;
                  shreg_q <= '0;
                  wide_q  <= wide;
               end
            end else begin
               cnt_q <= (cnt_q == WRAP_C) ? '0 : cnt_q + 1'b1;
               if (at_last) begin
                  if (state_q == RX_START) begin
                     state_q <= maj_now ? RX_IDLE : RX_DATA;
                  end else if (state_q == RX_DATA) begin
                     shreg_q <= {maj_now, shreg_q[DATA_W:1]};
                     idx_q   <= idx_q + 1'b1;
                     if (idx_q == (wide_q ? TOP_W : TOP_N)) state_q <= RX_STOP;
                  end else begin
                     char_done <= 1'b1;
                     stop_ok   <= maj_now;
                     state_q   <= RX_IDLE;
                  end
               end
            end
         end
      end
   end

   // LSB-first shifting leaves short characters one place high
   assign char_data = wide_q ? shreg_q : {1'b0, shreg_q[DATA_W:1]};

   // R10
   idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (state_q == RX_IDLE) && !char_done);

   // R3
   no_done_from_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      char_done |-> $past(state_q) == RX_STOP);

endmodule

// File: rtl/uart_vote_hold.sv
module uart_vote_hold #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              char_done,
   input  logic [DATA_W:0]   char_data,
   input  logic              stop_ok,
   input  logic              rd_stb,
   output logic [DATA_W-1:0] data_q,
   output logic              bit9_q,
   output logic              full_q,
   output logic              fe_q,
   output logic              ovr_vis_q
);

   logic rd_hit;
   logic ovr_pend_q;

   assign rd_hit = rd_stb && full_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q     <= '0;
         bit9_q     <= 1'b0;
         full_q     <= 1'b0;
         fe_q       <= 1'b0;
         ovr_pend_q <= 1'b0;
         ovr_vis_q  <= 1'b0;
      end else begin
         if (rd_hit) ovr_vis_q <= ovr_pend_q;
         if (char_done && (!full_q || rd_hit)) begin
            data_q <= char_data[DATA_W-1:0];
            bit9_q <= char_data[DATA_W];
            fe_q   <= !stop_ok;
            full_q <= 1'b1;
         end else if (rd_hit) begin
            full_q <= 1'b0;
         end
         if (char_done && full_q && !rd_hit) ovr_pend_q <= 1'b1;
         else if (rd_hit)                    ovr_pend_q <= 1'b0;
      end
   end

   // R5
   done_sets_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      char_done |=> full_q);

   // R7
   read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && full_q && !char_done) |=> !full_q);

   // R8
   drop_keeps_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (char_done && full_q && !rd_stb) |=> $stable(data_q) && $stable(fe_q));

   // R9
   ovr_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovr_vis_q) |-> $past(rd_stb));

endmodule

// File: rtl/uart_vote_rx.sv
module uart_vote_rx #(
   parameter int OSR         = 16,
   parameter int SAMP_FIRST  = 8,
   parameter int VOTES       = 3,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_en,
   input  logic              tick16,
   input  logic              rxd,
   input  logic              wide_mode,
   input  logic              rd_stb,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_bit9,
   output logic              rx_done,
   output logic              frame_err,
   output logic              overrun
);

   if (OSR < 4) begin : g_bad_osr
      $error("uart_vote_rx: OSR must be at least 4");
   end
   if (DATA_W < 2) begin : g_bad_width
      $error("uart_vote_rx: DATA_W must be at least 2");
   end

   logic            rxd_s;
   logic            smp_en;
   logic            maj_now;
   logic            char_done;
   logic [DATA_W:0] char_data;
   logic            stop_ok;

   uart_vote_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (rxd),
      .dout (rxd_s)
   );

   uart_vote_maj #(.VOTES(VOTES)) u_maj (
      .clk    (clk),
      .rst_n  (rst_n),
      .smp_en (smp_en),
      .smp    (rxd_s),
      .maj_now(maj_now)
   );

   uart_vote_frame #(
      .OSR(OSR), .SAMP_FIRST(SAMP_FIRST), .VOTES(VOTES), .DATA_W(DATA_W)
   ) u_frame (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (rx_en),
      .tick     (tick16),
      .rxd_s    (rxd_s),
      .wide     (wide_mode),
      .maj_now  (maj_now),
      .smp_en   (smp_en),
      .char_done(char_done),
      .char_data(char_data),
      .stop_ok  (stop_ok)
   );

   uart_vote_hold #(.DATA_W(DATA_W)) u_hold (
      .clk      (clk),
      .rst_n    (rst_n),
      .char_done(char_done),
      .char_data(char_data),
      .stop_ok  (stop_ok),
      .rd_stb   (rd_stb),
      .data_q   (rx_data),
      .bit9_q   (rx_bit9),
      .full_q   (rx_done),
      .fe_q     (frame_err),
      .ovr_vis_q(overrun)
   );

endmodule

// File: tb/uart_vote_rx_bench.sv
module uart_vote_rx_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_en = 1'b1;
   logic       rxd = 1'b1;
   logic       wide_mode = 1'b0;
   logic       rd_stb = 1'b0;
   logic [1:0] tdiv = 2'd0;
   logic       tick16;
   logic [7:0] rx_data;
   logic       rx_bit9, rx_done, frame_err, overrun;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;
   always_ff @(posedge clk) tdiv <= tdiv + 2'd1;
   assign tick16 = (tdiv == 2'd3);

   uart_vote_rx u_uart_vote_rx (
      .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .tick16(tick16), .rxd(rxd),
      .wide_mode(wide_mode), .rd_stb(rd_stb), .rx_data(rx_data),
      .rx_bit9(rx_bit9), .rx_done(rx_done), .frame_err(frame_err),
      .overrun(overrun)
   );

   // wide(1) data(9) data-bit-0 flips(16) stop flips(16)
   localparam int NV = 7;
   localparam logic [41:0] VEC [NV] = '{
      {1'b0, 9'h0A5, 16'h0000, 16'h0000},
      {1'b0, 9'h03C, 16'h0100, 16'h0000},
      {1'b0, 9'h001, 16'h0180, 16'h0000},
      {1'b1, 9'h15A, 16'h0000, 16'h0000},
      {1'b1, 9'h0FF, 16'h0000, 16'h0380},
      {1'b0, 9'h080, 16'h0000, 16'h0200},
      {1'b1, 9'h100, 16'hFC7F, 16'h0000}
   };

   task automatic check(input string req, input logic [9:0] act, input logic [9:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   function automatic logic vote(input logic [15:0] f);
      return (f[7] & f[8]) | (f[7] & f[9]) | (f[8] & f[9]);
   endfunction

   // one bit period: element k is seen by tick k (k=0 is the edge tick)
   task automatic seg(input logic v, input logic [15:0] flip);
      for (int k = 0; k < 16; k++) begin
         do @(negedge clk); while (tdiv != 2'd0);
         rxd = v ^ flip[k];
         @(posedge clk);
      end
   endtask

   task automatic send(input logic wide, input logic [8:0] d,
                       input logic [15:0] dflip, input logic [15:0] sflip);
      wide_mode = wide;
      seg(1'b0, 16'h0000);
      for (int b = 0; b < (wide ? 9 : 8); b++)
         seg(d[b], (b == 0) ? dflip : 16'h0000);
      seg(1'b1, sflip);
      seg(1'b1, 16'h0000);
      seg(1'b1, 16'h0000);
   endtask

   task automatic read_pulse();
      @(negedge clk); rd_stb = 1'b1;
      @(negedge clk); rd_stb = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=hung expected=done");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      check("R11 rx_done", {9'd0, rx_done}, 10'd0);
      check("R11 frame_err", {9'd0, frame_err}, 10'd0);
      check("R11 overrun", {9'd0, overrun}, 10'd0);
      check("R11 data", {rx_bit9, 1'b0, rx_data}, 10'd0);
      seg(1'b1, 16'h0000);

      for (int i = 0; i < NV; i++) begin
         logic       w;
         logic [8:0] d, e;
         logic [15:0] df, sf;
         {w, d, df, sf} = VEC[i];
         e = d;
         e[0] = d[0] ^ vote(df);
         if (!w) e[8] = 1'b0;
         send(w, d, df, sf);
         check("R5 rx_done after char", {9'd0, rx_done}, 10'd1);
         check("R1/R2 data", {2'd0, rx_data}, {2'd0, e[7:0]});
         check("R6 ninth bit", {9'd0, rx_bit9}, {9'd0, e[8]});
         check("R4 frame_err", {9'd0, frame_err}, {9'd0, vote(sf)});
         check("R9 no overrun", {9'd0, overrun}, 10'd0);
         read_pulse();
         check("R7 rx_done cleared", {9'd0, rx_done}, 10'd0);
      end

      // R3 false start: low only on ticks 0..6
      seg(1'b0, 16'hFF80);
      seg(1'b1, 16'h0000);
      seg(1'b1, 16'h0000);
      check("R3 false start no char", {9'd0, rx_done}, 10'd0);
      send(1'b0, 9'h05A, 16'h0, 16'h0);
      check("R3 next char", {2'd0, rx_data}, 10'h05A);
      read_pulse();

      // R8 / R9 overrun sequence
      send(1'b0, 9'h011, 16'h0, 16'h0);
      send(1'b0, 9'h022, 16'h0, 16'h0);
      check("R8 first char kept", {2'd0, rx_data}, 10'h011);
      check("R9 overrun hidden before read", {9'd0, overrun}, 10'd0);
      read_pulse();
      check("R9 overrun after read", {9'd0, overrun}, 10'd1);
      check("R8 dropped char not loaded", {9'd0, rx_done}, 10'd0);
      send(1'b0, 9'h033, 16'h0, 16'h0);
      check("R8 later char", {2'd0, rx_data}, 10'h033);
      read_pulse();
      check("R9 overrun cleared by read", {9'd0, overrun}, 10'd0);

      // R10 disabled receiver
      rx_en = 1'b0;
      send(1'b0, 9'h0C3, 16'h0, 16'h0);
      check("R10 disabled no char", {9'd0, rx_done}, 10'd0);
      check("R10 data untouched", {2'd0, rx_data}, 10'h033);
      rx_en = 1'b1;
      seg(1'b1, 16'h0000);
      send(1'b1, 9'h1E7, 16'h0, 16'h0);
      check("R10 char after enable", {rx_bit9, 1'b0, rx_data}, {1'b1, 1'b0, 8'hE7});

      finished = 1'b1;
      summary();
      $finish;
   end

endmodule